// File: doc/BRIEF.md
# Dual-Mode Timer Counter Channel

A single timer channel built around a free-running up-counter and three data registers, called A, B and C. Software reaches every register through a small memory-mapped bus with single-cycle write and read strobes. A start command clears the counter and sets it running. After that, the counter is also cleared by a pulse on a synchronous clear input, or when it reaches the value held in register C.

One mode bit picks the use of the channel. In capture mode, registers A and B record the counter when the input pin toggles. Each register has its own edge selection. In waveform mode, matches of the counter against A, B and C drive two output pins, which gives a pulse-width-modulated pair with period C+1.

Events set sticky status flags. Reading the status register clears them. An interrupt line is raised while any flag is set whose enable bit is also set.

Top module: `tmr_chan`

## Requirements
- R1: After reset the counter reads 0 and is stopped, A and B read 0, C reads 0xFFFF, mode, status and interrupt enable read 0, and `tioa_out`, `tiob_out` and `irq` are low.
- R2: Writing 1 to bit 0 of the control register (offset 0x00) clears the counter on that clock edge and starts counting, one step per clock. Before any start the counter holds its value. The counter reads at offset 0x10.
- R3: `sync_in` high during a clock cycle makes the counter read 0 after that edge, and counting continues from there.
- R4: While running, a counter equal to C (offset 0x1C) returns to 0 on the next edge and sets status bit 2. This holds in both modes.
- R5: The mode register (offset 0x04) has the mode bit at bit 0, the A edge selection at bits 2:1 and the B edge selection at bits 4:3. Edge codes are 0 none, 1 rising, 2 falling, 3 both. In capture mode (bit 0 = 0), a selected edge of `tioa_in` loads the counter into A (offset 0x14) or B (offset 0x18). The loaded value is the count seen two clocks after the pin changed, since the pin passes through a two-flop synchroniser.
- R6: A capture that falls in the same cycle as a counter clear stores the value the counter held before the clear.
- R7: In waveform mode, a counter match on A sets status bit 0 and a match on B sets status bit 1. In capture mode these two bits are never set by matches.
- R8: In waveform mode, `tioa_out` rises the cycle after an A match and falls the cycle after a C match. A clear wins over a set. Over one period of C+1 cycles it is high for C-A cycles when A < C, and 0 cycles otherwise. In capture mode the output is held low.
- R9: `tiob_out` follows the same rule with B in place of A.
- R10: Status (offset 0x20) is sticky. A read clears it on that edge, but a flag set on the same edge survives.
- R11: `irq` is high exactly when some status bit and its bit in the enable register (offset 0x24) are both 1.
- R12: A capture into A sets status bit 3, and a capture into B sets status bit 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (a status read clears it) |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational, 0 when not reading |
| sync_in | input | 1 | Synchronous counter clear |
| tioa_in | input | 1 | Capture pin, asynchronous |
| tioa_out | output | 1 | Waveform output A |
| tiob_out | output | 1 | Waveform output B |
| irq | output | 1 | Level interrupt |

## Verification
The assertions take for granted that `sync_in`, `bus_wr` and `bus_rd` are synchronous to `clk`. They also take for granted that the bus never writes register A in the same cycle that a capture loads it. Only `tioa_in` may change at any time.

The stimulus changes every input on the falling edge and samples on the falling edge as well. Each register is written only before a start command or while no capture edge is pending. Register C is loaded with a value above the running count, or a start follows at once, so the counter never runs the whole 16-bit range during a test.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  localparam logic [7:0] OFS_CTRL = 8'h00;
  localparam logic [7:0] OFS_MODE = 8'h04;
  localparam logic [7:0] OFS_CNT  = 8'h10;
  localparam logic [7:0] OFS_RA   = 8'h14;
  localparam logic [7:0] OFS_RB   = 8'h18;
  localparam logic [7:0] OFS_RC   = 8'h1C;
  localparam logic [7:0] OFS_STS  = 8'h20;
  localparam logic [7:0] OFS_IEN  = 8'h24;

  localparam int unsigned STS_W  = 5;
  localparam int unsigned ST_MA  = 0;
  localparam int unsigned ST_MB  = 1;
  localparam int unsigned ST_MC  = 2;
  localparam int unsigned ST_LA  = 3;
  localparam int unsigned ST_LB  = 4;

  typedef enum logic [1:0] {
    EDGE_NONE = 2'd0,
    EDGE_RISE = 2'd1,
    EDGE_FALL = 2'd2,
    EDGE_ANY  = 2'd3
  } edge_sel_e;

  typedef struct packed {
    logic [1:0] selb;
    logic [1:0] sela;
    logic       wave;
  } mode_t;

  function automatic logic edge_hit(input edge_sel_e sel, input logic rise, input logic fall);
    logic hit;
    case (sel)
      EDGE_RISE: hit = rise;
      EDGE_FALL: hit = fall;
      EDGE_ANY:  hit = rise | fall;
      default:   hit = 1'b0;
    endcase
    return hit;
  endfunction

endpackage

// File: rtl/tmr_in_sync.sv
module tmr_in_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic rise_o,
  output logic fall_o
);
  localparam int unsigned CW = STAGES + 1;

  logic [CW-1:0] chain_q, chain_d;

  always_comb begin
    chain_d = {chain_q[CW-2:0], pin_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rise_o =  chain_q[STAGES-1] & ~chain_q[STAGES];
  assign fall_o = ~chain_q[STAGES-1] &  chain_q[STAGES];

  AST_RISE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o); // R5
  AST_FALL_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    fall_o |=> !fall_o); // R5
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             sync_i,
  input  logic [CNT_W-1:0] rc_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             run_o,
  output logic             c_hit_o,
  output logic             clr_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             run_q, run_d;
  logic             cnt_en;

  assign c_hit_o = run_q && (cnt_q == rc_i);
  assign clr_o   = start_i | sync_i | c_hit_o;

  always_comb begin
    run_d  = run_q | start_i;
    cnt_en = clr_o | run_q;
    cnt_d  = cnt_q;
    if (clr_o)      cnt_d = '0;
    else if (run_q) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else begin
      run_q <= run_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  assign cnt_o = cnt_q;
  assign run_o = run_q;

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !clr_o) |=> (cnt_q == $past(cnt_q) + 1'b1)); // R2
  AST_CNT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !start_i && !sync_i) |=> $stable(cnt_q)); // R2
  AST_SYNC_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    sync_i |=> (cnt_q == '0)); // R3
  AST_C_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    c_hit_o |=> (cnt_q == '0)); // R4
endmodule

// File: rtl/tmr_wave.sv
module tmr_wave #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wave_i,
  input  logic             run_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] ra_i,
  input  logic [CNT_W-1:0] rb_i,
  input  logic             c_hit_i,
  output logic             a_hit_o,
  output logic             b_hit_o,
  output logic             tioa_o,
  output logic             tiob_o
);
  localparam int unsigned NCH = 2;

  logic [NCH-1:0]       hit;
  logic [NCH-1:0]       out_q, out_d;
  logic [CNT_W-1:0]     ref_v [NCH];

  assign ref_v[0] = ra_i;
  assign ref_v[1] = rb_i;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    assign hit[g] = wave_i && run_i && (cnt_i == ref_v[g]);

    always_comb begin
      out_d[g] = out_q[g];
      if (!wave_i)     out_d[g] = 1'b0;
      else if (c_hit_i) out_d[g] = 1'b0;
      else if (hit[g])  out_d[g] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_q <= '0;
    else        out_q <= out_d;
  end

  assign a_hit_o = hit[0];
  assign b_hit_o = hit[1];
  assign tioa_o  = out_q[0];
  assign tiob_o  = out_q[1];

  AST_WAVE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !wave_i |=> (!tioa_o && !tiob_o)); // R8
  AST_C_CLR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (wave_i && c_hit_i) |=> (!tioa_o && !tiob_o)); // R8
  AST_A_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (a_hit_o && !c_hit_i) |=> tioa_o); // R8
  AST_B_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (b_hit_o && !c_hit_i) |=> tiob_o); // R9
endmodule

// File: rtl/tmr_chan.sv
module tmr_chan #(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [CNT_W-1:0]  bus_wdata,
  output logic [CNT_W-1:0]  bus_rdata,
  input  logic              sync_in,
  input  logic              tioa_in,
  output logic              tioa_out,
  output logic              tiob_out,
  output logic              irq
);
  import tmr_pkg::*;

  localparam int unsigned MODE_W = $bits(mode_t);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe;
  logic       rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_ni = rst_pipe[1];

  // address decode
  logic sel_ctrl, sel_mode, sel_ra, sel_rb, sel_rc, sel_ien, sts_rd;
  assign sel_ctrl = bus_wr && (bus_addr == ADDR_W'(OFS_CTRL));
  assign sel_mode = bus_wr && (bus_addr == ADDR_W'(OFS_MODE));
  assign sel_ra   = bus_wr && (bus_addr == ADDR_W'(OFS_RA));
  assign sel_rb   = bus_wr && (bus_addr == ADDR_W'(OFS_RB));
  assign sel_rc   = bus_wr && (bus_addr == ADDR_W'(OFS_RC));
  assign sel_ien  = bus_wr && (bus_addr == ADDR_W'(OFS_IEN));
  assign sts_rd   = bus_rd && (bus_addr == ADDR_W'(OFS_STS));

  logic start;
  assign start = sel_ctrl && bus_wdata[0];

  logic unused_wdata;
  assign unused_wdata = ^bus_wdata[CNT_W-1:MODE_W];

  // state
  mode_t            mode_q, mode_d;
  logic [CNT_W-1:0] ra_q, ra_d, rb_q, rb_d, rc_q, rc_d;
  logic [STS_W-1:0] sts_q, sts_d, sts_set, ien_q, ien_d;
  logic             mode_en, ra_en, rb_en, rc_en, ien_en;

  // submodules
  logic             rise, fall;
  logic [CNT_W-1:0] cnt;
  logic             run, c_hit, cnt_clr, a_hit, b_hit;

  tmr_in_sync #(.STAGES(SYNC_N)) u_sync (
    .clk(clk), .rst_n(rst_ni), .pin_i(tioa_in), .rise_o(rise), .fall_o(fall)
  );

  tmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_ni), .start_i(start), .sync_i(sync_in), .rc_i(rc_q),
    .cnt_o(cnt), .run_o(run), .c_hit_o(c_hit), .clr_o(cnt_clr)
  );

  tmr_wave #(.CNT_W(CNT_W)) u_wave (
    .clk(clk), .rst_n(rst_ni), .wave_i(mode_q.wave), .run_i(run), .cnt_i(cnt),
    .ra_i(ra_q), .rb_i(rb_q), .c_hit_i(c_hit), .a_hit_o(a_hit), .b_hit_o(b_hit),
    .tioa_o(tioa_out), .tiob_o(tiob_out)
  );

  // capture selection
  logic cap_a, cap_b;
  assign cap_a = !mode_q.wave && edge_hit(edge_sel_e'(mode_q.sela), rise, fall);
  assign cap_b = !mode_q.wave && edge_hit(edge_sel_e'(mode_q.selb), rise, fall);

  always_comb begin
    sts_set        = '0;
    sts_set[ST_MA] = a_hit;
    sts_set[ST_MB] = b_hit;
    sts_set[ST_MC] = c_hit;
    sts_set[ST_LA] = cap_a;
    sts_set[ST_LB] = cap_b;
  end

  // next state
  always_comb begin
    mode_en = sel_mode;
    mode_d  = mode_t'(bus_wdata[MODE_W-1:0]);

    ra_en = cap_a | sel_ra;
    ra_d  = cap_a ? cnt : bus_wdata;
    rb_en = cap_b | sel_rb;
    rb_d  = cap_b ? cnt : bus_wdata;
    rc_en = sel_rc;
    rc_d  = bus_wdata;

    ien_en = sel_ien;
    ien_d  = bus_wdata[STS_W-1:0];

    sts_d = (sts_rd ? '0 : sts_q) | sts_set;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= '0;
      ra_q   <= '0;
      rb_q   <= '0;
      rc_q   <= '1;
      ien_q  <= '0;
      sts_q  <= '0;
    end else begin
      if (mode_en) mode_q <= mode_d;
      if (ra_en)   ra_q   <= ra_d;
      if (rb_en)   rb_q   <= rb_d;
      if (rc_en)   rc_q   <= rc_d;
      if (ien_en)  ien_q  <= ien_d;
      sts_q <= sts_d;
    end
  end

  // read mux
  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      case (bus_addr)
        ADDR_W'(OFS_MODE): bus_rdata = CNT_W'(mode_q);
        ADDR_W'(OFS_CNT):  bus_rdata = cnt;
        ADDR_W'(OFS_RA):   bus_rdata = ra_q;
        ADDR_W'(OFS_RB):   bus_rdata = rb_q;
        ADDR_W'(OFS_RC):   bus_rdata = rc_q;
        ADDR_W'(OFS_STS):  bus_rdata = CNT_W'(sts_q);
        ADDR_W'(OFS_IEN):  bus_rdata = CNT_W'(ien_q);
        default:           bus_rdata = '0;
      endcase
    end
  end

  assign irq = |(sts_q & ien_q);

  AST_STS_RDCLR: assert property (@(posedge clk) disable iff (!rst_ni)
    (sts_rd && (sts_set == '0)) |=> (sts_q == '0)); // R10
  AST_STS_STICKY: assert property (@(posedge clk) disable iff (!rst_ni)
    !sts_rd |=> ((sts_q & $past(sts_q)) == $past(sts_q))); // R10
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_ni)
    (ien_q == '0) |-> !irq); // R11
  AST_CAP_PRE_CLR: assert property (@(posedge clk) disable iff (!rst_ni)
    (cap_a && cnt_clr) |=> (ra_q == $past(cnt))); // R6
  AST_NO_MATCH_CAP: assert property (@(posedge clk) disable iff (!rst_ni)
    (!mode_q.wave && !sts_q[ST_MA]) |=> !sts_q[ST_MA]); // R7
endmodule

// File: tb/tmr_chan_test.sv
module tmr_chan_test;
  import tmr_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        sync_in = 1'b0, tioa_in = 1'b0;
  logic        tioa_out, tiob_out, irq;

  int total = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  tmr_chan uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sync_in(sync_in), .tioa_in(tioa_in),
    .tioa_out(tioa_out), .tiob_out(tiob_out), .irq(irq)
  );

  typedef struct packed {
    logic [15:0] ra, rb, rc, hia, hib;
  } pwm_vec_t;

  localparam int NVEC = 5;
  localparam pwm_vec_t VEC [NVEC] = '{
    '{16'd3,  16'd7,  16'd15, 16'd12, 16'd8},
    '{16'd0,  16'd10, 16'd10, 16'd10, 16'd0},
    '{16'd6,  16'd6,  16'd9,  16'd3,  16'd3},
    '{16'd12, 16'd2,  16'd9,  16'd0,  16'd7},
    '{16'd5,  16'd1,  16'd5,  16'd0,  16'd4}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [15:0] d);
    bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    logic [15:0] d, v, w;
    int ha, hb;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset values
    rd(OFS_CNT, d);  chk("R1 cnt", d, 16'h0);
    rd(OFS_RA, d);   chk("R1 ra", d, 16'h0);
    rd(OFS_RB, d);   chk("R1 rb", d, 16'h0);
    rd(OFS_RC, d);   chk("R1 rc", d, 16'hFFFF);
    rd(OFS_MODE, d); chk("R1 mode", d, 16'h0);
    rd(OFS_IEN, d);  chk("R1 ien", d, 16'h0);
    rd(OFS_STS, d);  chk("R1 sts", d, 16'h0);
    chk("R1 pins", {tioa_out, tiob_out, irq}, 3'b000);

    // R2 idle, start, step
    repeat (5) @(negedge clk);
    rd(OFS_CNT, d);  chk("R2 idle", d, 16'h0);
    wr(OFS_CTRL, 16'h1);
    rd(OFS_CNT, d);  chk("R2 after start", d, 16'd0);
    rd(OFS_CNT, d);  chk("R2 step", d, 16'd1);
    repeat (5) @(negedge clk);
    rd(OFS_CNT, d);  chk("R2 run", d, 16'd7);

    // R3 sync clear
    sync_in = 1'b1; @(negedge clk); sync_in = 1'b0;
    rd(OFS_CNT, d);  chk("R3 cleared", d, 16'd0);
    rd(OFS_CNT, d);  chk("R3 resumes", d, 16'd1);

    // R4 / R7 C wrap in capture mode
    wr(OFS_RC, 16'd20);
    wr(OFS_CTRL, 16'h1);
    rd(OFS_STS, d);
    repeat (19) @(negedge clk);
    rd(OFS_CNT, d);  chk("R4 at C", d, 16'd20);
    rd(OFS_CNT, d);  chk("R4 wrapped", d, 16'd0);
    rd(OFS_STS, d);  chk("R4 R7 sts only C", d, 16'h04);
    rd(OFS_STS, d);  chk("R10 read cleared", d, 16'h00);

    // R10 set wins over read clear
    wr(OFS_RC, 16'd10);
    wr(OFS_CTRL, 16'h1);
    repeat (10) @(negedge clk);
    rd(OFS_STS, d);
    rd(OFS_STS, d);  chk("R10 set wins", d, 16'h04);

    // R5 R12 capture: A on rising, B on falling
    wr(OFS_RC, 16'hFFFF);
    wr(OFS_MODE, 16'h0012);
    wr(OFS_CTRL, 16'h1);
    rd(OFS_STS, d);
    tioa_in = 1'b1; rd(OFS_CNT, v);
    repeat (5) @(negedge clk);
    rd(OFS_RA, d);   chk("R5 A rise", d, v + 16'd2);
    rd(OFS_STS, d);  chk("R12 A flag", d, 16'h08);
    tioa_in = 1'b0; rd(OFS_CNT, w);
    repeat (5) @(negedge clk);
    rd(OFS_RB, d);   chk("R5 B fall", d, w + 16'd2);
    rd(OFS_RA, d);   chk("R5 A ignores fall", d, v + 16'd2);
    rd(OFS_STS, d);  chk("R12 B flag", d, 16'h10);
    wr(OFS_MODE, 16'h0006);
    tioa_in = 1'b1; rd(OFS_CNT, v);
    repeat (5) @(negedge clk);
    rd(OFS_RA, d);   chk("R5 A any", d, v + 16'd2);
    rd(OFS_RB, d);   chk("R5 B none", d, w + 16'd2);

    // R6 capture coincides with C clear
    tioa_in = 1'b0;
    repeat (5) @(negedge clk);
    wr(OFS_MODE, 16'h0002);
    wr(OFS_RC, 16'd40);
    wr(OFS_CTRL, 16'h1);
    rd(OFS_STS, d);
    repeat (37) @(negedge clk);
    tioa_in = 1'b1;
    repeat (3) @(negedge clk);
    rd(OFS_CNT, d);  chk("R6 R4 cleared", d, 16'd0);
    rd(OFS_RA, d);   chk("R6 pre-clear value", d, 16'd40);
    rd(OFS_STS, d);  chk("R6 R12 flags", d, 16'h0C);

    // R7 R8 R9 waveform table
    for (int i = 0; i < NVEC; i++) begin
      wr(OFS_MODE, 16'h0001);
      wr(OFS_RA, VEC[i].ra);
      wr(OFS_RB, VEC[i].rb);
      wr(OFS_RC, VEC[i].rc);
      wr(OFS_CTRL, 16'h1);
      rd(OFS_STS, d);
      repeat (2 * (VEC[i].rc + 1)) @(negedge clk);
      ha = 0; hb = 0;
      for (int k = 0; k <= int'(VEC[i].rc); k++) begin
        ha += int'(tioa_out);
        hb += int'(tiob_out);
        @(negedge clk);
      end
      chk($sformatf("R8 tioa high v%0d", i), ha, VEC[i].hia);
      chk($sformatf("R9 tiob high v%0d", i), hb, VEC[i].hib);
      rd(OFS_STS, d);
      chk($sformatf("R7 match flags v%0d", i), d[1:0],
          {VEC[i].rb <= VEC[i].rc, VEC[i].ra <= VEC[i].rc});
    end
    wr(OFS_MODE, 16'h0000);
    @(negedge clk);
    chk("R8 R9 capture mode low", {tioa_out, tiob_out}, 2'b00);

    // R11 interrupt gating
    wr(OFS_RC, 16'd100);
    wr(OFS_IEN, 16'h01);
    rd(OFS_STS, d);
    wr(OFS_CTRL, 16'h1);
    repeat (105) @(negedge clk);
    chk("R11 masked", irq, 1'b0);
    wr(OFS_IEN, 16'h04);
    chk("R11 enabled", irq, 1'b1);
    rd(OFS_STS, d);  chk("R11 sts", d, 16'h04);
    chk("R11 cleared", irq, 1'b0);

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule